// File: doc/BRIEF.md
# Edge-Counting Frequency Comparator

This block judges which of two asynchronous square waves runs faster: an unknown input and a hard-limited reference taken from a frequency synthesizer. It counts rising edges of each signal inside a single period of the other. When one signal shows two rising edges before the other shows its next one, that signal is taken to be faster. The result is held in a direction latch. Its single registered output tells an external frequency-word counter to step up (reference too slow) or down (reference too fast). Everything runs on one system clock with a synchronous reset and an enable.

Each raw input first passes through a two-flop synchronizer and then a rising-edge detector. The detector produces a one-clock pulse per edge. Two three-state edge counters follow, each with states `CNT_ZERO`, `CNT_ONE` and `CNT_TWO`:

- The unknown-side counter advances on unknown edges and restarts on reference edges.
- The reference-side counter advances on reference edges and restarts on unknown edges.
- Each counter has three transitions: *advance* (ZERO→ONE, ONE→TWO), *saturate* (TWO→TWO) and *restart* (any state → ZERO, or → ONE when its own edge lands in the same clock as the restarting edge).
- The ONE→TWO advance fires a hit. A hit from the unknown side is the set request; a hit from the reference side is the clear request.

The direction latch is a two-state machine, `DIR_DOWN` and `DIR_UP`:

- *Raise* (DOWN→UP) on a set request alone.
- *Lower* (UP→DOWN) on a clear request alone.
- *Hold* otherwise, including when both requests arrive together.

When the two frequencies are equal the output simply swings between up and down. There is no equality flag. For a short time after a frequency step the decision can be wrong, until the faster signal again places two edges in one period of the slower one.

Top module: `edge_freq_comparator`

## Requirements
- R1: A synchronous reset forces `dir_up` to 0 on the next clock edge and returns both edge counters to `CNT_ZERO`. A single unknown edge before the reset is therefore forgotten.
- R2: Two rising edges of `sig_unknown` with no rising edge of `sig_ref` between them drive `dir_up` to 1 (count up).
- R3: Two rising edges of `sig_ref` with no rising edge of `sig_unknown` between them drive `dir_up` to 0 (count down).
- R4: A rising edge of the opposite input restarts a counter. The sequence unknown, reference, unknown therefore leaves `dir_up` unchanged.
- R5: A counter saturates at two and never wraps. Any run of unknown edges longer than two keeps `dir_up` at 1.
- R6: When set and clear requests occur in the same clock, `dir_up` keeps its value. Edges of both inputs in the same clock count as the first edge of a new period on both sides.
- R7: While `enable` is 0, the counters and `dir_up` are frozen, and input edges that arrive then have no effect afterwards.
- R8: Each detected edge is a one-clock pulse. `dir_up` changes at the third rising clock edge that samples a deciding input high: two synchronizer stages plus the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances counters and latch when 1 |
| sig_unknown | input | 1 | Raw asynchronous square wave to be measured |
| sig_ref | input | 1 | Raw asynchronous hard-limited reference |
| dir_up | output | 1 | 1 = raise reference frequency, 0 = lower it |

## Verification
The hardest case to reach from the ports is both direction requests firing in the same clock. The two counters restart each other, so they can only both reach `CNT_ONE` when edges of the two inputs are synchronized into the same cycle. The bench gets there by driving both raw inputs high on the same falling clock edge twice in a row, once from each latch state. It also confirms that the next single unknown edge then completes a pair. The enable freeze and the three-cycle output latency are checked cycle by cycle by sampling at the falling edge.

// File: rtl/efc_pkg.sv
package efc_pkg;

    // Per-period edge count of one input, measured against the other input
    typedef enum logic [1:0] {
        CNT_ZERO = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_TWO  = 2'd2
    } cnt_state_t;

    // Direction latch
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_state_t;

    localparam int unsigned NUM_CHAN = 2;  // 0: unknown, 1: reference

endpackage

// File: rtl/efc_sync_edge.sv
module efc_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int unsigned DEPTH = STAGES + 1;  // synchronizer stages plus previous-value flop

    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[DEPTH-2:0], din};
        end
    end

    always_comb begin
        rise = pipe[STAGES-1] & ~pipe[STAGES];
    end

    // An edge pulse lasts exactly one clock
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R8

endmodule

// File: rtl/efc_edge_counter.sv
module efc_edge_counter
    import efc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic own_edge,
    input  logic restart_edge,
    output logic hit
);
    cnt_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CNT_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: advance, saturate, restart
    always_comb begin
        state_d = state_q;
        if (en) begin
            if (restart_edge) begin
                state_d = own_edge ? CNT_ONE : CNT_ZERO;
            end else if (own_edge) begin
                unique case (state_q)
                    CNT_ZERO: state_d = CNT_ONE;
                    CNT_ONE:  state_d = CNT_TWO;
                    CNT_TWO:  state_d = CNT_TWO;
                    default:  state_d = CNT_ZERO;
                endcase
            end
        end
    end

    // Output: second edge within the current period
    always_comb begin
        hit = en && own_edge && (state_q == CNT_ONE);
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && state_q == CNT_TWO && !restart_edge) |=> state_q == CNT_TWO);  // R5

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (en && restart_edge && !own_edge) |=> state_q == CNT_ZERO);  // R4

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state_q));  // R7

endmodule

// File: rtl/efc_dir_latch.sv
module efc_dir_latch
    import efc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set_req,
    input  logic clr_req,
    output logic dir_up
);
    dir_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIR_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: raise, lower, hold
    always_comb begin
        state_d = state_q;
        if (en) begin
            unique case ({set_req, clr_req})
                2'b10:   state_d = DIR_UP;
                2'b01:   state_d = DIR_DOWN;
                default: state_d = state_q;
            endcase
        end
    end

    // Output
    always_comb begin
        dir_up = (state_q == DIR_UP);
    end

    AST_RESET_DOWN: assert property (@(posedge clk)
        rst |=> !dir_up);  // R1

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        (en && set_req && !clr_req) |=> dir_up);  // R2

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (en && clr_req && !set_req) |=> !dir_up);  // R3

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && set_req && clr_req) |=> $stable(dir_up));  // R6

    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dir_up));  // R7

endmodule

// File: rtl/edge_freq_comparator.sv
module edge_freq_comparator
    import efc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sig_unknown,
    input  logic sig_ref,
    output logic dir_up
);
    logic [NUM_CHAN-1:0] raw_in;
    logic [NUM_CHAN-1:0] rise;
    logic [NUM_CHAN-1:0] hit;

    always_comb begin
        raw_in = {sig_ref, sig_unknown};
    end

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        efc_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .rise (rise[g])
        );

        efc_edge_counter u_cnt (
            .clk          (clk),
            .rst          (rst),
            .en           (enable),
            .own_edge     (rise[g]),
            .restart_edge (rise[NUM_CHAN-1-g]),
            .hit          (hit[g])
        );
    end

    efc_dir_latch u_dir (
        .clk     (clk),
        .rst     (rst),
        .en      (enable),
        .set_req (hit[0]),
        .clr_req (hit[1]),
        .dir_up  (dir_up)
    );

endmodule

// File: tb/edge_freq_comparator_tb.sv
`timescale 1ns/1ps
module edge_freq_comparator_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b1;
    logic sig_unknown = 1'b0;
    logic sig_ref = 1'b0;
    logic dir_up;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    edge_freq_comparator u_dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .sig_unknown (sig_unknown),
        .sig_ref     (sig_ref),
        .dir_up      (dir_up)
    );

    task automatic check(input logic act, input logic exp, input string req);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: dir_up actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at falling edges; a pulse is high two clocks, low two clocks
    task automatic pulse(input logic u, input logic r);
        @(negedge clk);
        sig_unknown = u;
        sig_ref = r;
        repeat (2) @(negedge clk);
        sig_unknown = 1'b0;
        sig_ref = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sig_unknown = 1'b0;
        sig_ref = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(dir_up, 1'b0, "R1 reset state");
        pulse(1, 0);
        pulse(1, 0);
        check(dir_up, 1'b1, "R1 setup");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dir_up, 1'b0, "R1 reset from up");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        pulse(1, 0);           // counter at ONE
        do_reset();
        pulse(1, 0);           // must be first edge again
        check(dir_up, 1'b0, "R1 counter cleared");
    endtask

    task automatic t_set_clear();
        do_reset();
        pulse(1, 0);
        check(dir_up, 1'b0, "R2 one edge not enough");
        pulse(1, 0);
        check(dir_up, 1'b1, "R2 two unknown edges");
        pulse(0, 1);
        check(dir_up, 1'b1, "R3 one ref edge not enough");
        pulse(0, 1);
        check(dir_up, 1'b0, "R3 two ref edges");
    endtask

    task automatic t_restart();
        do_reset();
        pulse(1, 0);
        pulse(0, 1);
        pulse(1, 0);
        check(dir_up, 1'b0, "R4 interleaved from down");
        pulse(1, 0);
        check(dir_up, 1'b1, "R4 pair completes after restart");
        pulse(0, 1);
        pulse(1, 0);
        pulse(0, 1);
        check(dir_up, 1'b1, "R4 interleaved from up");
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 5; i++) pulse(1, 0);
        check(dir_up, 1'b1, "R5 long unknown run");
        pulse(0, 1);
        check(dir_up, 1'b1, "R5 single ref after run");
        pulse(0, 1);
        check(dir_up, 1'b0, "R5 ref pair after run");
    endtask

    task automatic t_simultaneous();
        do_reset();
        pulse(1, 1);
        pulse(1, 1);
        check(dir_up, 1'b0, "R6 both requests hold down");
        pulse(1, 0);
        check(dir_up, 1'b1, "R6 same-cycle edge counted as first");
        pulse(1, 1);
        pulse(1, 1);
        check(dir_up, 1'b1, "R6 both requests hold up");
    endtask

    task automatic t_enable();
        do_reset();
        @(negedge clk);
        enable = 1'b0;
        pulse(1, 0);
        pulse(1, 0);
        check(dir_up, 1'b0, "R7 frozen while disabled");
        @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        check(dir_up, 1'b0, "R7 no effect after enable");
        pulse(1, 0);
        check(dir_up, 1'b0, "R7 ignored edges not counted");
        pulse(1, 0);
        check(dir_up, 1'b1, "R7 normal after enable");
    endtask

    task automatic t_latency();
        do_reset();
        pulse(1, 0);
        @(negedge clk);
        sig_unknown = 1'b1;
        repeat (2) @(negedge clk);
        check(dir_up, 1'b0, "R8 not before third edge");
        @(negedge clk);
        check(dir_up, 1'b1, "R8 at third edge");
        sig_unknown = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_set_clear();
        t_restart();
        t_saturate();
        t_simultaneous();
        t_enable();
        t_latency();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule